// File: doc/BRIEF.md
# Fractional-Period Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds for a precision time protocol engine. Every time the selected reference source delivers a tick, the counter advances by a programmable period. The period has two parts. The integer part is 10 bits of whole nanoseconds. The fractional part is a 32-bit addend in which 2^32 stands for one nanosecond. The addend is summed into a private accumulator, and the carry out of that accumulator adds one further nanosecond on the same tick. Software can therefore set the average tick period with a resolution far below one nanosecond.

Software reaches the block through a plain single-cycle register port. Read data is registered and appears on the cycle after the read strobe. Every access completes at once, so the port has no back-pressure and no handshake. The 64-bit count is accessed as two 32-bit words, and the order of the accesses keeps each 64-bit access consistent. A read of the low word also freezes the high word, and a later high-word read returns that frozen value. A write of the low word is only held aside. The following high-word write then loads all 64 bits into the counter together.

A prescaler divides the accepted ticks down to a square-wave output clock. Reference ticks arrive as one-cycle strobes that are already synchronous to `clk`. Clock-domain crossing of those strobes is done outside the block.

Top module: `tod_counter_top`

## Requirements
- R1: After reset the count is 0, the control and addend registers read 0, the prescaler reads 2 and `gclk_out` is low.
- R2: The control word is at offset 0x80. It holds the source select in bits [1:0], the enable in bit 2 and the integer period in bits [25:16], and every other bit reads 0. The addend is at 0xA0 and reads back as written. Unmapped offsets read 0.
- R3: Each accepted tick adds the integer period, in nanoseconds, to the count.
- R4: Each accepted tick adds the addend to a 32-bit fraction accumulator that starts at 0. A carry out of that sum adds one extra nanosecond to the count on the same tick. A counter load leaves the accumulator unchanged.
- R5: A source select code of 0, 1 or 2 takes ticks only from `ref_tick[code]`. Code 3 accepts no ticks.
- R6: While the enable bit is 0, the count and the fraction accumulator hold their values whatever the tick inputs do, and a counter load is still accepted.
- R7: A read of the low word (0x98) returns the live low 32 bits and captures the high 32 bits in the same cycle. A read of the high word (0x9C) returns the captured value, even if the count has carried into the high word since the capture.
- R8: A write to 0x98 does not change the count. A write to 0x9C loads {written high word, last written low word} into the count on the next cycle. In that cycle the load takes priority over a tick, and the tick's increment and accumulator update are both dropped.
- R9: The prescaler is at 0xA8 with a width of 16 bits. An odd value written is stored as the next even value, and reads return the stored value.
- R10: `gclk_out` toggles once for every prescaler/2 accepted ticks, so it has a 50% duty cycle. A stored value of 0 behaves like 2. Writing the prescaler restarts its tick count.
- R11: `reg_rdata` is valid on the cycle after `reg_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 3 | One-cycle tick strobes, one per reference source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tod_ns | output | 64 | Current nanosecond count |
| gclk_out | output | 1 | Prescaled output clock |

## Verification
The hardest case to reach from the ports is a low-word read followed by a carry from the low word into the high word before the high word is read. The bench loads a count a few nanoseconds below a 32-bit boundary. It reads the low word and then releases exactly one tick. It then reads the high word and expects the pre-carry value, while a fresh pair of reads shows the carried value. Fraction carries are reached by sweeping periods and addends, including 0xFFFFFFFF and 0x80000000, against a per-tick arithmetic model.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned PERIOD_W = 10;
  localparam int unsigned SRC_W    = 2;
  // field positions inside the control word
  localparam int unsigned SRC_LSB  = 0;
  localparam int unsigned EN_BIT   = 2;
  localparam int unsigned PER_LSB  = 16;
  // register offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_ADDEND = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_PRSC   = 8'hA8;

  typedef struct packed {
    logic [PERIOD_W-1:0] period;
    logic                enable;
    logic [SRC_W-1:0]    src;
  } tod_cfg_t;
endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRSC_W   = 16,
  parameter int unsigned PRSC_RST = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] cnt,
  output logic [DATA_W-1:0]   rdata,
  output tod_cfg_t            cfg,
  output logic [DATA_W-1:0]   addend,
  output logic [PRSC_W-1:0]   prsc,
  output logic                prsc_wr,
  output logic                load_en,
  output logic [2*DATA_W-1:0] load_val
);
  logic [DATA_W-1:0] pend_lo, shadow_hi, rd_mux;
  logic [PRSC_W-1:0] prsc_in;
  logic              wr_ctrl, wr_lo, wr_add, rd_lo;

  assign wr_ctrl  = wr && (addr == OFS_CTRL);
  assign wr_lo    = wr && (addr == OFS_CNT_LO);
  assign wr_add   = wr && (addr == OFS_ADDEND);
  assign prsc_wr  = wr && (addr == OFS_PRSC);
  assign load_en  = wr && (addr == OFS_CNT_HI);
  assign rd_lo    = rd && (addr == OFS_CNT_LO);
  assign load_val = {wdata, pend_lo};
  // an odd prescale value is rounded up to the next even one
  assign prsc_in  = wdata[PRSC_W-1:0] + PRSC_W'(wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      addend    <= '0;
      prsc      <= PRSC_W'(PRSC_RST);
      pend_lo   <= '0;
      shadow_hi <= '0;
      rdata     <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.src    <= wdata[SRC_LSB +: SRC_W];
        cfg.enable <= wdata[EN_BIT];
        cfg.period <= wdata[PER_LSB +: PERIOD_W];
      end
      if (wr_add)  addend  <= wdata;
      if (prsc_wr) prsc    <= prsc_in;
      if (wr_lo)   pend_lo <= wdata;
      if (rd_lo)   shadow_hi <= cnt[2*DATA_W-1:DATA_W];
      if (rd)      rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFS_CTRL: begin
        rd_mux[SRC_LSB +: SRC_W]    = cfg.src;
        rd_mux[EN_BIT]              = cfg.enable;
        rd_mux[PER_LSB +: PERIOD_W] = cfg.period;
      end
      OFS_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      OFS_CNT_HI: rd_mux = shadow_hi;
      OFS_ADDEND: rd_mux = addend;
      OFS_PRSC:   rd_mux = DATA_W'(prsc);
      default:    rd_mux = '0;
    endcase
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned FRAC_W   = 32,
  parameter int unsigned PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  input  logic [FRAC_W-1:0]   addend,
  input  logic                load_en,
  input  logic [CNT_W-1:0]    load_val,
  output logic [CNT_W-1:0]    cnt
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic [CNT_W-1:0]  step;

  assign frac_sum = {1'b0, frac_q} + {1'b0, addend};
  assign step     = CNT_W'(period) + CNT_W'(frac_sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      frac_q <= '0;
    end else if (load_en) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt    <= cnt + step;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tod_clkdiv.sv
module tod_clkdiv #(
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PRSC_W-1:0] prsc,
  input  logic              restart,
  output logic              gclk
);
  localparam int unsigned HALF_W = PRSC_W - 1;
  logic [HALF_W-1:0] half, half_eff, cnt_q;

  assign half     = prsc[PRSC_W-1:1];
  assign half_eff = (half == '0) ? HALF_W'(1) : half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gclk  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == half_eff - HALF_W'(1)) begin
        cnt_q <= '0;
        gclk  <= ~gclk;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_counter_top.sv
module tod_counter_top
  import tod_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRSC_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  ref_tick,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*DATA_W-1:0] tod_ns,
  output logic                gclk_out
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  tod_cfg_t          cfg;
  logic [DATA_W-1:0] addend;
  logic [PRSC_W-1:0] prsc;
  logic              prsc_wr, load_en, src_tick, tmr_tick;
  logic [CNT_W-1:0]  load_val;

  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (cfg.src == SRC_W'(i)) src_tick = ref_tick[i];
  end
  assign tmr_tick = src_tick & cfg.enable;

  tod_regfile #(.DATA_W(DATA_W), .PRSC_W(PRSC_W), .PRSC_RST(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(tod_ns), .rdata(reg_rdata), .cfg(cfg),
    .addend(addend), .prsc(prsc), .prsc_wr(prsc_wr), .load_en(load_en),
    .load_val(load_val)
  );

  tod_accum #(.CNT_W(CNT_W), .FRAC_W(DATA_W), .PERIOD_W(PERIOD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .period(cfg.period),
    .addend(addend), .load_en(load_en), .load_val(load_val), .cnt(tod_ns)
  );

  tod_clkdiv #(.PRSC_W(PRSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .prsc(prsc),
    .restart(prsc_wr), .gclk(gclk_out)
  );
endmodule

// File: rtl/tod_counter_checker.sv
module tod_counter_checker
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tmr_tick,
  input logic                load_en,
  input logic [2*DATA_W-1:0] load_val,
  input logic [PERIOD_W-1:0] period,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [2*DATA_W-1:0] tod_ns,
  input logic                gclk_out
);
  // R6: with neither tick nor load, the count holds
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_tick && !load_en) |=> $stable(tod_ns));

  // R3 / R4: a tick adds the period, plus at most one fractional carry
  assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && !load_en) |=>
      ((tod_ns - $past(tod_ns)) == 64'($past(period))) ||
      ((tod_ns - $past(tod_ns)) == 64'($past(period)) + 64'd1));

  // R8: a high-word write loads the assembled value
  assert_load_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> tod_ns == $past(load_val));

  // R7 / R11: a low-word read returns the live low word one cycle later
  assert_low_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_CNT_LO) |=> reg_rdata == $past(tod_ns[DATA_W-1:0]));

  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R10: the output clock only moves after an accepted tick
  assert_gclk_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gclk_out) |-> $past(tmr_tick));
endmodule

bind tod_counter_top tod_counter_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .load_en(load_en),
  .load_val(load_val), .period(cfg.period), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tod_ns(tod_ns),
  .gclk_out(gclk_out)
);

// File: tb/test_tod_counter_top.sv
module test_tod_counter_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ref_tick = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] tod_ns;
  logic        gclk_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_cnt = '0;
  logic [31:0] m_frac = '0, m_add = '0;
  logic [9:0]  m_per = '0;

  always #2 clk = ~clk;

  tod_counter_top i_tod_counter_top (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tod_ns(tod_ns), .gclk_out(gclk_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(8'h98, lo); rd(8'h9C, hi); v = {hi, lo};
  endtask

  task automatic ticks(input int s, input int n);
    @(negedge clk); ref_tick[s] = 1;
    repeat (n) @(negedge clk);
    ref_tick = '0;
  endtask

  task automatic model(input int n);
    for (int k = 0; k < n; k++) begin
      logic [32:0] s;
      s = {1'b0, m_frac} + {1'b0, m_add};
      m_frac = s[31:0];
      m_cnt = m_cnt + 64'(m_per) + 64'(s[32]);
    end
  endtask

  task automatic setcfg(input int src, input int en, input int per);
    wr(8'h80, (32'(per) << 16) | (32'(en) << 2) | 32'(src));
    m_per = 10'(per);
  endtask

  task automatic setadd(input logic [31:0] a);
    wr(8'hA0, a); m_add = a;
  endtask

  task automatic load(input logic [63:0] v);
    wr(8'h98, v[31:0]); wr(8'h9C, v[63:32]); m_cnt = v;
  endtask

  task automatic gclk_run(input logic [31:0] p, input int half, input int n);
    int tog = 0;
    logic prev;
    wr(8'hA8, p);
    prev = gclk_out;
    for (int k = 0; k < n; k++) begin
      ticks(0, 1);
      if (gclk_out !== prev) tog++;
      prev = gclk_out;
    end
    model(n);
    chk($sformatf("R10 toggles prsc=%0d", p), 64'(tog), 64'(n / half));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    int per_l[3] = '{1, 8, 1023};
    logic [31:0] add_l[4] = '{32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h80, d); chk("R1 ctrl", 64'(d), 0);
    rd(8'hA0, d); chk("R1 addend", 64'(d), 0);
    rd(8'hA8, d); chk("R1 prescaler", 64'(d), 2);
    rd64(v);      chk("R1 count", v, 0);
    chk("R1 gclk", 64'(gclk_out), 0);

    // R2 field layout and decode
    wr(8'h80, 32'hFFFF_FFFF); rd(8'h80, d); chk("R2 ctrl mask", 64'(d), 64'h03FF_0007);
    wr(8'h80, 0);
    setadd(32'hDEAD_BEEF); rd(8'hA0, d); chk("R2 addend", 64'(d), 64'hDEAD_BEEF);
    rd(8'hA4, d); chk("R2 unmapped", 64'(d), 0);
    rd64(v); chk("R2 count untouched", v, 0);

    // R8 write ordering
    wr(8'h98, 32'h0000_0011); rd64(v); chk("R8 low write alone", v, 0);
    wr(8'h9C, 32'h0000_0022); m_cnt = 64'h22_0000_0011;
    rd64(v); chk("R8 high write loads", v, m_cnt);

    // R3/R4 sweep over periods and addends
    foreach (per_l[i]) foreach (add_l[j]) begin
      setadd(add_l[j]);
      setcfg(0, 1, per_l[i]);
      ticks(0, 37); model(37);
      setcfg(0, 0, per_l[i]);
      rd64(v);
      chk($sformatf("R3 R4 per=%0d add=%h", per_l[i], add_l[j]), v, m_cnt);
    end

    // R4 carry on the same tick
    load(64'h100); setadd(32'hFFFF_FFFF); setcfg(0, 1, 4);
    ticks(0, 1); model(1); rd64(v); chk("R4 single tick", v, m_cnt);
    ticks(0, 1); model(1); rd64(v); chk("R4 carry tick", v, m_cnt);

    // R5 source selection
    setadd(0); setcfg(1, 1, 5);
    ticks(0, 10); ticks(2, 10); rd64(v); chk("R5 other sources ignored", v, m_cnt);
    ticks(1, 3); model(3); rd64(v); chk("R5 source 1", v, m_cnt);
    setcfg(2, 1, 7); ticks(2, 4); model(4); rd64(v); chk("R5 source 2", v, m_cnt);
    setcfg(3, 1, 7);
    @(negedge clk); ref_tick = '1; repeat (6) @(negedge clk); ref_tick = '0;
    rd64(v); chk("R5 code 3 no ticks", v, m_cnt);

    // R6 disable holds count and fraction, loads still accepted
    setadd(32'h8000_0000); setcfg(0, 1, 3); ticks(0, 1); model(1);
    setcfg(0, 0, 3); ticks(0, 9); rd64(v); chk("R6 hold while off", v, m_cnt);
    load(64'h55_0000_1000); rd64(v); chk("R6 load while off", v, m_cnt);
    setcfg(0, 1, 3); ticks(0, 1); model(1); rd64(v); chk("R6 fraction held", v, m_cnt);

    // R7 coherent read across a low-word wrap
    setcfg(0, 0, 20); setadd(0); load(64'h1_FFFF_FFF0);
    setcfg(0, 1, 20);
    rd(8'h98, d); chk("R7 low read", 64'(d), 64'hFFFF_FFF0);
    ticks(0, 1); model(1);
    chk("R11 rdata held", 64'(reg_rdata), 64'hFFFF_FFF0);
    rd(8'h9C, d); chk("R7 high is captured", 64'(d), 64'h1);
    rd64(v); chk("R7 fresh pair", v, m_cnt);

    // R9 prescaler rounding, R10 output clock
    wr(8'hA8, 5); rd(8'hA8, d); chk("R9 odd rounded up", 64'(d), 6);
    wr(8'hA8, 8); rd(8'hA8, d); chk("R9 even kept", 64'(d), 8);
    setcfg(0, 1, 1);
    gclk_run(2, 1, 8);
    gclk_run(4, 2, 12);
    gclk_run(5, 3, 12);
    gclk_run(10, 5, 20);
    gclk_run(0, 1, 6);
    setcfg(0, 0, 1); rd64(v); chk("R3 after divider runs", v, m_cnt);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule